// File: doc/BRIEF.md
# Peripheral DMA Channel

This block is one DMA channel that copies 32-bit words between a peripheral port and a memory port. Software sets it up with a small register file: a control word, a status word, a fixed peripheral address (a device FIFO) and a memory base address. Once the enable bit is set, the channel copies words one at a time. Each word is a read handshake on the source side followed by a write handshake on the destination side. When flow control is on, each word also waits for the hardware request line chosen by a 5-bit selector.

There are two modes. In one-shot mode the channel copies the programmed count once, turns itself off and flags end-of-count. In continuous mode the programmed count is half the buffer. End-of-count is flagged after each half, a ping-pong status bit flips to show which half finished, and the memory address goes back to the base after the second half. The channel keeps running until software clears enable.

Selector code 31 is never granted. Software can use it to freeze a flow-controlled copy between words and read back an exact residual count.

Top module: `dma_chan`

## Requirements
- R1: After a synchronous active-low reset, the control word, the status word, the interrupt and both bus strobes are all 0.
- R2: A one-shot run copies (count field, control bits 15:2) + 1 words. Control bit 28 = 0 copies from the peripheral to memory; bit 28 = 1 copies from memory to the peripheral. The memory address starts at the memory base and rises by 4 per word. The peripheral address stays at the peripheral base.
- R3: When a one-shot run (control bit 27 = 1) finishes its last word, control bit 31 (enable) clears, status bit 31 (busy) falls and status bit 30 (end-of-count) is set, all on the same clock edge.
- R4: The interrupt output is high exactly when status bit 30 and control bit 30 (interrupt enable) are both 1.
- R5: Writing the status word with bit 30 = 1 clears end-of-count. A status write with bit 30 = 0 leaves it unchanged. If a new end-of-count event arrives in the same cycle as a clear, the set wins.
- R6: In continuous mode (bit 27 = 0), end-of-count is set after every (count + 1) words. The channel stays enabled and busy. The memory address returns to the base after every second half.
- R7: Status bit 28 (ping-pong) is 0 after enable and flips each time a half completes in continuous mode.
- R8: With control bit 21 = 1 (flow control), a word starts only while the request line chosen by control bits 20:16 is high. Selector 31 is never granted. While the channel waits on selector 31, status bit 29 (halt) is 1 and no bus strobe is raised.
- R9: Status bits 15:2 hold the number of words still to copy in the current run or half, minus one. The value does not change while the channel is halted.
- R10: Clearing enable during a run lets the word in progress finish and then stops the channel. End-of-count is not set, and the residual count stays readable.
- R11: Busy rises on the second clock edge after enable is written. Busy never rises while enable is 0.
- R12: Each bus strobe, once raised, stays high until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 status, 2 peripheral address, 3 memory base |
| cfg_wdata | input | 32 | Register write data |
| ctrl_q | output | 32 | Control word readback |
| stat_q | output | 32 | Status word readback |
| irq | output | 1 | End-of-count interrupt |
| req_lines | input | NREQ | Hardware request lines |
| per_stb | output | 1 | Peripheral access strobe |
| per_we | output | 1 | Peripheral access is a write |
| per_addr | output | AW | Peripheral address |
| per_wdata | output | DW | Peripheral write data |
| per_rdata | input | DW | Peripheral read data |
| per_ack | input | 1 | Peripheral access done |
| mem_stb | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ack | input | 1 | Memory access done |

## Verification
The hardest state to reach from the ports is a flow-controlled run frozen between two words, with a known number already copied.

To get there, the bench raises the selected request line and watches the peripheral model's read counter. It drops the line as soon as the third read is accepted. It then switches the selector to the invalid code and drives every request line high, so a grant could only come from a decode fault. Halt, the frozen residual and the unchanged transfer counters are then checked before the selector is restored and the run finishes.

// File: rtl/dma_chan_pkg.sv
// Package: shared state type and register field positions for the DMA channel.
// Assumes a 32-bit register word; the field positions are decoded by software.
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GATE = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } eng_state_t;

    localparam logic [1:0] RA_CTRL  = 2'd0;
    localparam logic [1:0] RA_STAT  = 2'd1;
    localparam logic [1:0] RA_PADDR = 2'd2;
    localparam logic [1:0] RA_MADDR = 2'd3;

    // control word fields
    localparam int unsigned C_EN     = 31;
    localparam int unsigned C_IE     = 30;
    localparam int unsigned C_DIR    = 28;
    localparam int unsigned C_ONCE   = 27;
    localparam int unsigned C_FLOW   = 21;
    localparam int unsigned C_SEL_LO = 16;
    localparam int unsigned C_CNT_LO = 2;

    // status word fields
    localparam int unsigned S_BUSY   = 31;
    localparam int unsigned S_EOC    = 30;
    localparam int unsigned S_HALT   = 29;
    localparam int unsigned S_PP     = 28;
    localparam int unsigned S_CNT_LO = 2;

endpackage

// File: rtl/dma_chan_regs.sv
// Module: configuration registers and the end-of-count flag.
// Holds the control fields and the two base addresses, and keeps the sticky
// end-of-count flag. Assumes single-cycle writes. A one-shot completion
// clears enable after any write made in the same cycle.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 14,
    parameter int unsigned SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic             done_once,
    input  logic             eoc_evt,
    output logic             en,
    output logic             ie,
    output logic             dir,
    output logic             once,
    output logic             flow,
    output logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] wcnt,
    output logic [AW-1:0]    per_base,
    output logic [AW-1:0]    mem_base,
    output logic             eoc_flag
);

    logic wr_ctrl, wr_stat, wr_padr, wr_madr;
    logic unused_wbits;

    assign wr_ctrl = cfg_we && (cfg_addr == RA_CTRL);
    assign wr_stat = cfg_we && (cfg_addr == RA_STAT);
    assign wr_padr = cfg_we && (cfg_addr == RA_PADDR);
    assign wr_madr = cfg_we && (cfg_addr == RA_MADDR);
    assign unused_wbits = ^cfg_wdata[1:0];

    // Control fields: loaded by software, enable cleared by one-shot completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            ie   <= 1'b0;
            dir  <= 1'b0;
            once <= 1'b0;
            flow <= 1'b0;
            sel  <= '0;
            wcnt <= '0;
        end else begin
            if (wr_ctrl) begin
                en   <= cfg_wdata[C_EN];
                ie   <= cfg_wdata[C_IE];
                dir  <= cfg_wdata[C_DIR];
                once <= cfg_wdata[C_ONCE];
                flow <= cfg_wdata[C_FLOW];
                sel  <= cfg_wdata[C_SEL_LO +: SEL_W];
                wcnt <= cfg_wdata[C_CNT_LO +: CNT_W];
            end
            if (done_once) begin
                en <= 1'b0;
            end
        end
    end

    // Base addresses: word aligned, low two bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_base <= '0;
            mem_base <= '0;
        end else begin
            if (wr_padr) per_base <= {cfg_wdata[AW-1:2], 2'b00};
            if (wr_madr) mem_base <= {cfg_wdata[AW-1:2], 2'b00};
        end
    end

    // End-of-count flag: set by the engine, cleared by write-one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_flag <= 1'b0;
        end else if (eoc_evt) begin
            eoc_flag <= 1'b1;
        end else if (wr_stat && cfg_wdata[S_EOC]) begin
            eoc_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_chan_cursor.sv
// Module: residual word count, memory address and ping-pong half tracker.
// Loads on channel start and steps once per completed word. In continuous
// mode it reloads the count at each half boundary and rewinds the address
// after the second half. Assumes load and step never coincide.
module dma_chan_cursor #(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             once,
    input  logic [CNT_W-1:0] wcnt,
    input  logic [AW-1:0]    mem_base,
    output logic [CNT_W-1:0] rem,
    output logic [AW-1:0]    maddr,
    output logic             pp,
    output logic             last
);

    localparam logic [AW-1:0] WORD_BYTES = AW'(4);

    assign last = (rem == '0);

    // Count, address and half indicator update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            maddr <= '0;
            pp    <= 1'b0;
        end else if (load) begin
            rem   <= wcnt;
            maddr <= mem_base;
            pp    <= 1'b0;
        end else if (step) begin
            maddr <= maddr + WORD_BYTES;
            if (!last) begin
                rem <= rem - CNT_W'(1);
            end else if (!once) begin
                rem <= wcnt;
                pp  <= ~pp;
                if (pp) begin
                    maddr <= mem_base;
                end
            end
        end
    end

endmodule

// File: rtl/dma_chan_engine.sv
// Module: word-move sequencer.
// Gates each word on the selected request line (when flow control is on),
// reads one word from the source, then writes it to the destination.
// Assumes the bus ports hold ack for one cycle per strobe. A strobe stays
// up until its ack, so a cleared enable takes effect between words only.
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned NREQ  = 32,
    parameter int unsigned SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dir,
    input  logic             once,
    input  logic             flow,
    input  logic [SEL_W-1:0] sel,
    input  logic [NREQ-1:0]  req_lines,
    input  logic             last,
    input  logic [DW-1:0]    per_rdata,
    input  logic             per_ack,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ack,
    output logic             per_stb,
    output logic             mem_stb,
    output logic             bus_we,
    output logic [DW-1:0]    wdata,
    output logic             load,
    output logic             step,
    output logic             eoc_evt,
    output logic             done_once,
    output logic             busy,
    output logic             halt
);

    localparam logic [SEL_W-1:0] SEL_NONE = SEL_W'(NREQ - 1);

    eng_state_t state_q, state_d;
    logic       sel_ok, grant, rd_ack, wr_ack;
    logic [DW-1:0] rd_data;

    assign sel_ok  = (sel != SEL_NONE);
    assign grant   = !flow || (sel_ok && req_lines[sel]);
    assign rd_ack  = dir ? mem_ack : per_ack;
    assign wr_ack  = dir ? per_ack : mem_ack;
    assign rd_data = dir ? mem_rdata : per_rdata;

    assign load      = (state_q == ST_IDLE) && en;
    assign step      = (state_q == ST_WR) && wr_ack;
    assign eoc_evt   = step && last;
    assign done_once = eoc_evt && once;
    assign busy      = (state_q != ST_IDLE);
    assign halt      = (state_q == ST_GATE) && en && flow && !sel_ok;

    assign per_stb = ((state_q == ST_RD) && !dir) || ((state_q == ST_WR) && dir);
    assign mem_stb = ((state_q == ST_RD) && dir)  || ((state_q == ST_WR) && !dir);
    assign bus_we  = (state_q == ST_WR);

    // Next-state selection for the per-word sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en) state_d = ST_GATE;
            ST_GATE: begin
                if (!en)        state_d = ST_IDLE;
                else if (grant) state_d = ST_RD;
            end
            ST_RD:   if (rd_ack) state_d = ST_WR;
            ST_WR: begin
                if (wr_ack) begin
                    if (done_once || !en) state_d = ST_IDLE;
                    else                  state_d = ST_GATE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Word holding register between the read and write phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata <= '0;
        end else if ((state_q == ST_RD) && rd_ack) begin
            wdata <= rd_data;
        end
    end

endmodule

// File: rtl/dma_chan.sv
// Module: top of the single DMA channel.
// Wires the register file, the sequencer and the cursor together and builds
// the control and status readback words and the interrupt.
// Assumes one outstanding access per side.
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned NREQ  = 32,
    parameter int unsigned CNT_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    output logic [31:0]     ctrl_q,
    output logic [31:0]     stat_q,
    output logic            irq,
    input  logic [NREQ-1:0] req_lines,
    output logic            per_stb,
    output logic            per_we,
    output logic [AW-1:0]   per_addr,
    output logic [DW-1:0]   per_wdata,
    input  logic [DW-1:0]   per_rdata,
    input  logic            per_ack,
    output logic            mem_stb,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack
);

    localparam int unsigned SEL_W = $clog2(NREQ);

    logic             en, ie, dir, once, flow, eoc_flag;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] wcnt, rem;
    logic [AW-1:0]    per_base, mem_base, maddr;
    logic             load, step, eoc_evt, done_once, busy, halt, pp, last, bus_we;
    logic [DW-1:0]    wdata;

    dma_chan_regs #(.AW(AW), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .done_once (done_once),
        .eoc_evt   (eoc_evt),
        .en        (en),
        .ie        (ie),
        .dir       (dir),
        .once      (once),
        .flow      (flow),
        .sel       (sel),
        .wcnt      (wcnt),
        .per_base  (per_base),
        .mem_base  (mem_base),
        .eoc_flag  (eoc_flag)
    );

    dma_chan_engine #(.AW(AW), .DW(DW), .NREQ(NREQ), .SEL_W(SEL_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .dir       (dir),
        .once      (once),
        .flow      (flow),
        .sel       (sel),
        .req_lines (req_lines),
        .last      (last),
        .per_rdata (per_rdata),
        .per_ack   (per_ack),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .per_stb   (per_stb),
        .mem_stb   (mem_stb),
        .bus_we    (bus_we),
        .wdata     (wdata),
        .load      (load),
        .step      (step),
        .eoc_evt   (eoc_evt),
        .done_once (done_once),
        .busy      (busy),
        .halt      (halt)
    );

    dma_chan_cursor #(.AW(AW), .CNT_W(CNT_W)) u_cur (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .once     (once),
        .wcnt     (wcnt),
        .mem_base (mem_base),
        .rem      (rem),
        .maddr    (maddr),
        .pp       (pp),
        .last     (last)
    );

    assign per_we    = bus_we;
    assign mem_we    = bus_we;
    assign per_addr  = per_base;
    assign mem_addr  = maddr;
    assign per_wdata = wdata;
    assign mem_wdata = wdata;
    assign irq       = eoc_flag && ie;

    // Readback words assembled from the distributed state.
    always_comb begin
        ctrl_q = '0;
        ctrl_q[C_EN]   = en;
        ctrl_q[C_IE]   = ie;
        ctrl_q[C_DIR]  = dir;
        ctrl_q[C_ONCE] = once;
        ctrl_q[C_FLOW] = flow;
        ctrl_q[C_SEL_LO +: SEL_W] = sel;
        ctrl_q[C_CNT_LO +: CNT_W] = wcnt;
        stat_q = '0;
        stat_q[S_BUSY] = busy;
        stat_q[S_EOC]  = eoc_flag;
        stat_q[S_HALT] = halt;
        stat_q[S_PP]   = pp;
        stat_q[S_CNT_LO +: CNT_W] = rem;
    end

endmodule

// File: rtl/dma_chan_sva.sv
// Module: property checker for the DMA channel, bound to the top module.
// Observes only port-level values of the top.
module dma_chan_sva #(
    parameter int unsigned CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ie,
    input logic             once,
    input logic             busy,
    input logic             eoc,
    input logic             halt,
    input logic [CNT_W-1:0] rem,
    input logic             irq,
    input logic             per_stb,
    input logic             per_ack,
    input logic             mem_stb,
    input logic             mem_ack
);

    p_irq_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (eoc && ie));
    p_irq_need_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && ie) |-> irq);
    p_once_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(eoc) && once) |-> (!en && !busy));
    p_cont_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(eoc) && !once && en) |-> busy);
    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!per_stb && !mem_stb));
    p_halt_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> busy);
    p_rem_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && $past(halt)) |-> $stable(rem));
    p_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> !busy);
    p_per_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (per_stb && !per_ack) |=> per_stb);
    p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && !mem_ack) |=> mem_stb);

endmodule

bind dma_chan dma_chan_sva #(.CNT_W(CNT_W)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_q[31]),
    .ie      (ctrl_q[30]),
    .once    (ctrl_q[27]),
    .busy    (stat_q[31]),
    .eoc     (stat_q[30]),
    .halt    (stat_q[29]),
    .rem     (stat_q[2 +: CNT_W]),
    .irq     (irq),
    .per_stb (per_stb),
    .per_ack (per_ack),
    .mem_stb (mem_stb),
    .mem_ack (mem_ack)
);

// File: tb/tb_dma_chan.sv
module tb_dma_chan;

    localparam int unsigned AW    = 32;
    localparam int unsigned DW    = 32;
    localparam int unsigned NREQ  = 32;
    localparam int unsigned CNT_W = 14;

    // {control word, expected words (7 bits), expected irq}
    localparam logic [39:0] VEC [4] = '{
        {32'hC800_000C, 7'd4, 1'b1},
        {32'h9800_0000, 7'd1, 1'b0},
        {32'hD800_0014, 7'd6, 1'b1},
        {32'h8822_0008, 7'd3, 1'b0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n;
    logic            cfg_we;
    logic [1:0]      cfg_addr;
    logic [31:0]     cfg_wdata;
    logic [31:0]     ctrl_q, stat_q;
    logic            irq;
    logic [NREQ-1:0] req_lines;
    logic            per_stb, per_we, per_ack, mem_stb, mem_we, mem_ack;
    logic [AW-1:0]   per_addr, mem_addr;
    logic [DW-1:0]   per_wdata, per_rdata, mem_wdata, mem_rdata;

    dma_chan dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q), .stat_q(stat_q), .irq(irq),
        .req_lines(req_lines),
        .per_stb(per_stb), .per_we(per_we), .per_addr(per_addr),
        .per_wdata(per_wdata), .per_rdata(per_rdata), .per_ack(per_ack),
        .mem_stb(mem_stb), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // bus models and transfer logs
    logic [31:0] pwlog [64];
    logic [31:0] mwlog [64];
    int          per_rd_cnt = 0, per_wr_cnt = 0, mem_wr_cnt = 0, per_addr_bad = 0;
    logic        log_clr = 1'b0;
    localparam logic [AW-1:0] PER_BASE = 32'h0000_0040;

    always @(posedge clk) begin
        if (!rst_n) begin
            per_ack <= 1'b0;
            mem_ack <= 1'b0;
        end else begin
            per_ack <= per_stb && !per_ack;
            mem_ack <= mem_stb && !mem_ack;
        end
        if (log_clr) begin
            per_rd_cnt   <= 0;
            per_wr_cnt   <= 0;
            mem_wr_cnt   <= 0;
            per_addr_bad <= 0;
        end else begin
            if (per_stb && !per_ack) begin
                if (per_addr != PER_BASE) per_addr_bad <= per_addr_bad + 1;
                if (per_we) begin
                    pwlog[per_wr_cnt[5:0]] <= per_wdata;
                    per_wr_cnt <= per_wr_cnt + 1;
                end else begin
                    per_rdata  <= 32'hA000_0000 + 32'(per_rd_cnt);
                    per_rd_cnt <= per_rd_cnt + 1;
                end
            end
            if (mem_stb && !mem_ack) begin
                if (mem_we) begin
                    mwlog[mem_addr[7:2]] <= mem_wdata;
                    mem_wr_cnt <= mem_wr_cnt + 1;
                end else begin
                    mem_rdata <= 32'hB000_0000 | 32'(mem_addr[7:2]);
                end
            end
        end
    end

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_logs();
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        for (int i = 0; i < 2000 && stat_q[31]; i++) @(negedge clk);
    endtask

    task automatic wait_eoc();
        for (int i = 0; i < 2000 && !stat_q[30]; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; req_lines = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", ctrl_q, 32'h0, "control after reset");
        chk("R1", stat_q, 32'h0, "status after reset");
        chk("R1", {30'd0, irq, per_stb | mem_stb}, 32'h0, "irq/strobes after reset");
        rst_n = 1'b1;

        cfg_write(2'd2, PER_BASE);
        cfg_write(2'd3, 32'h0000_0100);

        // Table walk: one-shot runs in both directions, R2/R3/R4
        for (int v = 0; v < 4; v++) begin
            logic [31:0] cw;
            int          words, bad, wr_n;
            logic        dir_b;
            cw    = VEC[v][39:8];
            words = int'(VEC[v][7:1]);
            dir_b = cw[28];
            clear_logs();
            cfg_write(2'd1, 32'h4000_0000);
            req_lines = 32'h0000_0004;
            cfg_write(2'd0, cw);
            wait_idle();
            chk("R3", {31'd0, ctrl_q[31]}, 32'h0, "enable after one-shot");
            chk("R3", {30'd0, stat_q[31:30]}, 32'h1, "busy/eoc after one-shot");
            chk("R4", {31'd0, irq}, {31'd0, VEC[v][0]}, "irq after one-shot");
            bad = 0;
            for (int i = 0; i < words; i++) begin
                logic [31:0] e, a;
                e = dir_b ? (32'hB000_0000 | 32'(i)) : (32'hA000_0000 + 32'(i));
                a = dir_b ? pwlog[i] : mwlog[i];
                if (a !== e) bad++;
            end
            wr_n = dir_b ? per_wr_cnt : mem_wr_cnt;
            chk("R2", 32'(wr_n), 32'(words), "words written");
            chk("R2", 32'(bad), 32'h0, "word mismatches");
            chk("R2", 32'(per_addr_bad), 32'h0, "peripheral address moves");
        end

        // R5: clear behaviour with the channel idle and eoc set
        cfg_write(2'd1, 32'hBFFF_FFFF);
        chk("R5", {31'd0, stat_q[30]}, 32'h1, "eoc kept on write without bit 30");
        cfg_write(2'd1, 32'h4000_0000);
        chk("R5", {31'd0, stat_q[30]}, 32'h0, "eoc cleared by write-one");
        cfg_write(2'd0, 32'h4000_0000);
        chk("R4", {31'd0, irq}, 32'h0, "irq low with eoc clear");

        // Continuous mode, memory to peripheral, 2 words per half: R6/R7/R11
        clear_logs();
        cfg_write(2'd0, 32'hD000_0004);
        chk("R11", {31'd0, stat_q[31]}, 32'h0, "busy not yet one edge after enable");
        @(negedge clk);
        chk("R11", {31'd0, stat_q[31]}, 32'h1, "busy two edges after enable");
        chk("R7", {31'd0, stat_q[28]}, 32'h0, "ping-pong after enable");
        wait_eoc();
        chk("R7", {31'd0, stat_q[28]}, 32'h1, "ping-pong after first half");
        chk("R6", {30'd0, ctrl_q[31], stat_q[31]}, 32'h3, "still enabled and busy");
        chk("R4", {31'd0, irq}, 32'h1, "irq at half");
        cfg_write(2'd1, 32'h4000_0000);
        chk("R5", {31'd0, stat_q[30]}, 32'h0, "eoc cleared mid-run");
        wait_eoc();
        chk("R7", {31'd0, stat_q[28]}, 32'h0, "ping-pong after second half");
        cfg_write(2'd1, 32'h4000_0000);
        wait_eoc();
        chk("R7", {31'd0, stat_q[28]}, 32'h1, "ping-pong after third half");
        cfg_write(2'd0, 32'h5000_0004);
        wait_idle();
        chk("R6", {31'd0, 1'(per_wr_cnt >= 6)}, 32'h1, "words across three halves");
        for (int i = 0; i < 6; i++) begin
            chk("R6", pwlog[i], 32'hB000_0000 | 32'(i % 4), "address rewinds after second half");
        end

        // Flow control and the frozen residual: R8/R9
        cfg_write(2'd1, 32'h4000_0000);
        clear_logs();
        req_lines = '0;
        cfg_write(2'd0, 32'h8825_001C);
        repeat (10) @(negedge clk);
        chk("R8", 32'(per_rd_cnt), 32'h0, "no word without request");
        chk("R8", {30'd0, stat_q[31], stat_q[29]}, 32'h2, "busy, no halt on valid selector");
        req_lines[5] = 1'b1;
        for (int i = 0; i < 500 && per_rd_cnt < 3; i++) @(negedge clk);
        req_lines = '0;
        cfg_write(2'd0, 32'h883F_001C);
        req_lines = '1;
        repeat (20) @(negedge clk);
        chk("R8", {30'd0, stat_q[31], stat_q[29]}, 32'h3, "busy and halt on invalid selector");
        chk("R8", 32'(per_rd_cnt), 32'h3, "no read while halted");
        chk("R9", {18'd0, stat_q[15:2]}, 32'h4, "residual after three words");
        repeat (5) @(negedge clk);
        chk("R9", {18'd0, stat_q[15:2]}, 32'h4, "residual frozen");
        chk("R8", 32'(mem_wr_cnt), 32'h3, "no write while halted");
        cfg_write(2'd0, 32'h8825_001C);
        wait_idle();
        chk("R8", 32'(mem_wr_cnt), 32'h8, "completes after selector restored");
        chk("R3", {31'd0, stat_q[30]}, 32'h1, "eoc after flow run");

        // Disable mid-run: R10
        cfg_write(2'd1, 32'h4000_0000);
        clear_logs();
        req_lines = '0;
        cfg_write(2'd0, 32'hC800_003C);
        repeat (12) @(negedge clk);
        cfg_write(2'd0, 32'h4800_003C);
        wait_idle();
        begin
            int w;
            w = mem_wr_cnt;
            chk("R10", {18'd0, stat_q[15:2]}, 32'(15 - w), "residual after disable");
            chk("R10", {30'd0, stat_q[30], irq}, 32'h0, "no eoc on disable");
            chk("R10", 32'(per_rd_cnt), 32'(w), "word in progress completed");
            repeat (20) @(negedge clk);
            chk("R10", 32'(mem_wr_cnt), 32'(w), "no writes after stop");
            chk("R11", {31'd0, stat_q[31]}, 32'h0, "busy stays low while disabled");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule